// File: doc/BRIEF.md
# Dual-Bank Flash Read-Mode Tracker

This block tracks the command state of a flash device whose array is split into two banks that work together. Decoded bus cycles come in on a simple synchronous host port. Each cycle is a write (a command or command data) or a read. The block keeps a read mode for each bank: array, status or identifier. It runs a single program or erase operation at a time, times it with a cycle counter, and records an erase that has been suspended so that a program in the same bank can be slipped in. The array storage is a behavioural word memory.

A read is steered by the mode of the bank that holds the address. The bank is chosen by the most significant address bit: 0 selects bank a and 1 selects bank b. While one bank is busy, the other bank can still be read. An identifier read made during an operation is gated by the boot-block placement parameter. A refused identifier read is flagged, and its data is all ones.

Command codes live in the low byte of the write data: FFh read array, 70h read status, 90h read identifier, 40h program setup, 20h erase setup, D0h confirm/resume, B0h erase suspend.

Top module: `dbank_mode_tracker`

## Requirements
- R1: A program takes two writes: 40h, then a write that carries the target address and data. An erase takes 20h, then D0h at an address inside the block. If the write after 20h is not D0h, no operation starts, and that write is taken only as the second half of the pair.
- R2: When an operation launches (a start or a resume), the bank it belongs to switches to status mode and the other bank switches to array mode. A bank is always in status mode while its operation runs.
- R3: A read goes to the bank chosen by address bit AW-1. A read of the idle bank in array mode returns stored array data while the other bank is busy.
- R4: A status read returns bit 7 = ready (no operation running in that bank) and bit 6 = an erase is suspended in that bank. All other bits are 0.
- R5: A program runs for PROG_CYC cycles and an erase runs for ERASE_CYC cycles. After that the status shows ready. A program stores the AND of the old word and the new data. An erase sets every word of the 2^BLK_W-word block to all ones. The bank stays in status mode until FFh is written to it.
- R6: While an operation runs in a bank, FFh and 90h written to that bank are ignored. A new start to either bank is rejected.
- R7: B0h written to a bank whose erase is running halts the erase and leaves the status at ready+suspended. During the suspension only a program in the same bank may start. An erase, or an operation in the other bank, is rejected.
- R8: D0h written, outside an erase pair, to the bank with a suspended erase resumes it. The erase then finishes its remaining cycles and clears its block.
- R9: With no operation running, a read of a bank in identifier mode returns ID_WORD.
- R10: During an operation, an identifier read is served only when BOOT_TOP=0 and the running operation is in bank b. Otherwise it is refused: rd_refused=1 and rd_data is all ones.
- R11: After reset, both banks are in array mode, every word is all ones and no operation is running.
- R12: A read presented at a clock edge is answered at that same edge with rd_valid=1. The source codes are 0 array, 1 status, 2 identifier, 3 refused. The mode codes are 0 array, 1 status, 2 identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is presented this clock |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | AW | Word address; the top bit selects the bank |
| bus_wdata | input | DW | Write data or command code (low byte) |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DW | Read response data |
| rd_src | output | 2 | Source of the response (R12 codes) |
| rd_refused | output | 1 | The identifier read was refused |
| mode_a | output | 2 | Current mode of bank a |
| mode_b | output | 2 | Current mode of bank b |

## Verification
A program is started in one bank while reads alternate between that bank and the other one. This separates routing by address bit from routing by the last command. Reads placed one cycle before and one cycle after the expected completion pin down the operation length exactly. A suspend, a program in the same bank and then a resume, combined with rejected starts in the other bank, separate the saved-erase path from the normal start path. Two instances, built for the two boot placements and fed the same stimulus, show that only the identifier gating differs between them.

// File: rtl/dbank_pkg.sv
// Shared types and command codes for the dual-bank read-mode tracker.
// Assumes commands are carried in the low byte of a write.
package dbank_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_ID     = 2'd2
    } bank_mode_e;

    typedef enum logic [1:0] {
        SRC_ARRAY   = 2'd0,
        SRC_STATUS  = 2'd1,
        SRC_ID      = 2'd2,
        SRC_REFUSED = 2'd3
    } rd_src_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;
    localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_RD_ID       = 8'h90;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
endpackage

// File: rtl/dbank_cmd_dec.sv
// Command decoder: turns write cycles into request strobes.
// It holds the first half of a program or erase pair. The write that
// follows a setup write is always taken as its second half.
module dbank_cmd_dec
    import dbank_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          cmd_bank,
    output logic          start_req,
    output op_kind_e      start_kind,
    output logic [AW-1:0] start_addr,
    output logic [DW-1:0] start_data,
    output logic          req_rd_array,
    output logic          req_rd_status,
    output logic          req_rd_id,
    output logic          req_suspend,
    output logic          req_resume
);
    logic       pend_valid;
    op_kind_e   pend_kind;
    logic [7:0] cmd;

    assign cmd        = wr_data[7:0];
    assign cmd_bank   = wr_addr[AW-1];
    assign start_kind = pend_kind;
    assign start_addr = wr_addr;
    assign start_data = wr_data;

    // Decode the current write into a single request strobe.
    always_comb begin
        start_req     = 1'b0;
        req_rd_array  = 1'b0;
        req_rd_status = 1'b0;
        req_rd_id     = 1'b0;
        req_suspend   = 1'b0;
        req_resume    = 1'b0;
        if (wr_en) begin
            if (pend_valid) begin
                start_req = (pend_kind == OP_PROG) || (cmd == CMD_CONFIRM);
            end else begin
                case (cmd)
                    CMD_RD_ARRAY:  req_rd_array  = 1'b1;
                    CMD_RD_STATUS: req_rd_status = 1'b1;
                    CMD_RD_ID:     req_rd_id     = 1'b1;
                    CMD_SUSPEND:   req_suspend   = 1'b1;
                    CMD_CONFIRM:   req_resume    = 1'b1;
                    default:       ;
                endcase
            end
        end
    end

    // Remember a setup write until the next write arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_kind  <= OP_PROG;
        end else if (wr_en) begin
            pend_valid <= !pend_valid &&
                          (cmd == CMD_PROG_SETUP || cmd == CMD_ERASE_SETUP);
            if (!pend_valid)
                pend_kind <= (cmd == CMD_ERASE_SETUP) ? OP_ERASE : OP_PROG;
        end
    end

    AST_SETUP_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pend_valid) |=> !pend_valid); // R1
endmodule

// File: rtl/dbank_op_engine.sv
// Operation engine: runs at most one program or erase at a time and
// keeps the context of one suspended erase. The bank of an operation
// is the top bit of its address.
module dbank_op_engine
    import dbank_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_bank,
    input  logic          start_req,
    input  op_kind_e      start_kind,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_data,
    input  logic          req_suspend,
    input  logic          req_resume,
    output logic          running,
    output logic          op_bank,
    output logic          susp_valid,
    output logic          susp_bank,
    output logic          launch,
    output logic          launch_bank,
    output logic          done,
    output op_kind_e      done_kind,
    output logic [AW-1:0] done_addr,
    output logic [DW-1:0] done_data
);
    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    op_kind_e      op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic [CW-1:0] cnt;
    logic [AW-1:0] susp_addr;
    logic [CW-1:0] susp_left;
    logic          start_ok, resume_ok, suspend_ok;

    assign op_bank   = op_addr[AW-1];
    assign susp_bank = susp_addr[AW-1];
    assign done      = running && (cnt == CW'(1));
    assign done_kind = op_kind;
    assign done_addr = op_addr;
    assign done_data = op_data;

    // Decide which requests are accepted this cycle.
    always_comb begin
        start_ok   = start_req && !running &&
                     (!susp_valid ||
                      (start_kind == OP_PROG && start_addr[AW-1] == susp_bank));
        resume_ok  = req_resume && !running && susp_valid && (cmd_bank == susp_bank);
        suspend_ok = req_suspend && running && !done &&
                     (op_kind == OP_ERASE) && (cmd_bank == op_bank);
        launch      = start_ok || resume_ok;
        launch_bank = start_ok ? start_addr[AW-1] : susp_bank;
    end

    // Start, resume, suspend, count down and finish operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running    <= 1'b0;
            op_kind    <= OP_PROG;
            op_addr    <= '0;
            op_data    <= '0;
            cnt        <= '0;
            susp_valid <= 1'b0;
            susp_addr  <= '0;
            susp_left  <= '0;
        end else if (start_ok) begin
            running <= 1'b1;
            op_kind <= start_kind;
            op_addr <= start_addr;
            op_data <= start_data;
            cnt     <= (start_kind == OP_PROG) ? CW'(PROG_CYC) : CW'(ERASE_CYC);
        end else if (resume_ok) begin
            running    <= 1'b1;
            op_kind    <= OP_ERASE;
            op_addr    <= susp_addr;
            cnt        <= susp_left;
            susp_valid <= 1'b0;
        end else if (suspend_ok) begin
            running    <= 1'b0;
            susp_valid <= 1'b1;
            susp_addr  <= op_addr;
            susp_left  <= cnt;
        end else if (done) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt - CW'(1);
        end
    end

    AST_NO_NESTED_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && susp_valid) |-> (op_kind == OP_PROG)); // R7
    AST_SUSPEND_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_ok |=> (!running && susp_valid)); // R7
    AST_LAUNCH_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> running); // R5
    AST_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !running); // R5
endmodule

// File: rtl/dbank_mode_reg.sv
// Read-mode register of one bank. A launch sets this bank to status if
// the operation is its own, and to array otherwise. Mode commands
// addressed to this bank act only if no operation runs in it, except
// read status, which always acts.
module dbank_mode_reg
    import dbank_pkg::*;
#(
    parameter bit IDX = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       launch_bank,
    input  logic       cmd_bank,
    input  logic       req_rd_array,
    input  logic       req_rd_status,
    input  logic       req_rd_id,
    input  logic       busy_here,
    output bank_mode_e mode
);
    // Update the mode on launches and on mode commands to this bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_ARRAY;
        end else if (launch) begin
            mode <= (launch_bank == IDX) ? MODE_STATUS : MODE_ARRAY;
        end else if (cmd_bank == IDX) begin
            if (req_rd_status)
                mode <= MODE_STATUS;
            else if (req_rd_array && !busy_here)
                mode <= MODE_ARRAY;
            else if (req_rd_id && !busy_here)
                mode <= MODE_ID;
        end
    end

    AST_BUSY_SHOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_here |-> (mode == MODE_STATUS)); // R2
    AST_PEER_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && launch_bank != IDX) |=> (mode == MODE_ARRAY)); // R2
endmodule

// File: rtl/dbank_array.sv
// Behavioural flash array. A program ANDs the data into one word. An
// erase sets a whole block of 2^BLK_W words to ones. Reset fills the
// array with ones. The read port is combinational.
module dbank_array
    import dbank_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int BLK_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  op_kind_e      wr_kind,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    // Apply the finishing operation to the storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '1;
        end else if (wr_en) begin
            if (wr_kind == OP_PROG) begin
                mem[wr_addr] <= mem[wr_addr] & wr_data;
            end else begin
                for (int w = 0; w < DEPTH; w++)
                    if ((AW'(w) >> BLK_W) == (wr_addr >> BLK_W)) mem[w] <= '1;
            end
        end
    end
endmodule

// File: rtl/dbank_mode_tracker.sv
// Top of the dual-bank read-mode tracker. It decodes host writes into
// commands, runs one operation at a time, and answers each read from
// the mode of the addressed bank, one cycle later. BOOT_TOP selects
// the rule for identifier reads made while an operation runs.
module dbank_mode_tracker
    import dbank_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          DW        = 16,
    parameter int          BLK_W     = 4,
    parameter int          PROG_CYC  = 8,
    parameter int          ERASE_CYC = 40,
    parameter bit          BOOT_TOP  = 1'b0,
    parameter logic [15:0] ID_WORD   = 16'h2C17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    rd_src,
    output logic          rd_refused,
    output logic [1:0]    mode_a,
    output logic [1:0]    mode_b
);
    logic          wr_en, rd_en;
    logic          cmd_bank, start_req;
    op_kind_e      start_kind;
    logic [AW-1:0] start_addr;
    logic [DW-1:0] start_data;
    logic          req_rd_array, req_rd_status, req_rd_id, req_suspend, req_resume;
    logic          running, op_bank, susp_valid, susp_bank, launch, launch_bank, done;
    op_kind_e      done_kind;
    logic [AW-1:0] done_addr;
    logic [DW-1:0] done_data;
    logic [DW-1:0] arr_data;
    bank_mode_e    mode_q [2];
    logic          rbank, id_ok;
    bank_mode_e    sel_mode;
    rd_src_e       nx_src;
    logic [DW-1:0] nx_data, stat_word;

    assign wr_en  = bus_valid && bus_we;
    assign rd_en  = bus_valid && !bus_we;
    assign mode_a = mode_q[0];
    assign mode_b = mode_q[1];

    dbank_cmd_dec #(.AW(AW), .DW(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .cmd_bank(cmd_bank), .start_req(start_req),
        .start_kind(start_kind), .start_addr(start_addr), .start_data(start_data),
        .req_rd_array(req_rd_array), .req_rd_status(req_rd_status),
        .req_rd_id(req_rd_id), .req_suspend(req_suspend), .req_resume(req_resume)
    );

    dbank_op_engine #(.AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd_bank(cmd_bank), .start_req(start_req),
        .start_kind(start_kind), .start_addr(start_addr), .start_data(start_data),
        .req_suspend(req_suspend), .req_resume(req_resume), .running(running),
        .op_bank(op_bank), .susp_valid(susp_valid), .susp_bank(susp_bank),
        .launch(launch), .launch_bank(launch_bank), .done(done),
        .done_kind(done_kind), .done_addr(done_addr), .done_data(done_data)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        dbank_mode_reg #(.IDX(1'(g))) u_mode (
            .clk(clk), .rst_n(rst_n), .launch(launch), .launch_bank(launch_bank),
            .cmd_bank(cmd_bank), .req_rd_array(req_rd_array),
            .req_rd_status(req_rd_status), .req_rd_id(req_rd_id),
            .busy_here(running && (op_bank == 1'(g))), .mode(mode_q[g])
        );
    end

    dbank_array #(.AW(AW), .DW(DW), .BLK_W(BLK_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_en(done), .wr_kind(done_kind),
        .wr_addr(done_addr), .wr_data(done_data), .rd_addr(bus_addr), .rd_data(arr_data)
    );

    // Pick the read source from the mode of the addressed bank.
    always_comb begin
        rbank        = bus_addr[AW-1];
        sel_mode     = mode_q[rbank];
        stat_word    = '0;
        stat_word[7] = !(running && op_bank == rbank);
        stat_word[6] = susp_valid && (susp_bank == rbank);
        id_ok        = !running || (!BOOT_TOP && op_bank == 1'b1);
        case (sel_mode)
            MODE_STATUS: begin nx_src = SRC_STATUS; nx_data = stat_word; end
            MODE_ID: begin
                if (id_ok) begin nx_src = SRC_ID;      nx_data = DW'(ID_WORD); end
                else       begin nx_src = SRC_REFUSED; nx_data = '1;           end
            end
            default:     begin nx_src = SRC_ARRAY;  nx_data = arr_data;  end
        endcase
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            rd_src     <= SRC_ARRAY;
            rd_refused <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data    <= nx_data;
                rd_src     <= nx_src;
                rd_refused <= (nx_src == SRC_REFUSED);
            end
        end
    end

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R12
    AST_IDLE_ID_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !running) |=> !rd_refused); // R9
    AST_TOPBOOT_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && BOOT_TOP && running && sel_mode == MODE_ID) |=> rd_refused); // R10
endmodule

// File: tb/test_dbank_mode_tracker.sv
// Directed bench. Two instances, built for the two boot placements, get
// the same stimulus. Inputs are driven and outputs sampled at negedges.
module test_dbank_mode_tracker;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 40;
    localparam logic [15:0] IDW = 16'h2C17;
    localparam logic [1:0] MA = 2'd0, MS = 2'd1, MI = 2'd2;
    localparam logic [1:0] SA = 2'd0, SS = 2'd1, SI = 2'd2, SR = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        rd_valid, rd_refused, t_rd_valid, t_rd_refused;
    logic [15:0] rd_data, t_rd_data;
    logic [1:0]  rd_src, mode_a, mode_b, t_rd_src, t_mode_a, t_mode_b;
    int          vectors = 0, fails = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    dbank_mode_tracker #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .BOOT_TOP(1'b0),
                         .ID_WORD(IDW)) i_dbank_mode_tracker (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_src(rd_src), .rd_refused(rd_refused),
        .mode_a(mode_a), .mode_b(mode_b));

    dbank_mode_tracker #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .BOOT_TOP(1'b1),
                         .ID_WORD(IDW)) i_dbank_mode_tracker_top (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(t_rd_valid),
        .rd_data(t_rd_data), .rd_src(t_rd_src), .rd_refused(t_rd_refused),
        .mode_a(t_mode_a), .mode_b(t_mode_b));

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Write cycle followed by a scoreboard check of both banks' modes.
    task automatic wr(input logic [7:0] a, input logic [15:0] d,
                      input logic [1:0] ema, input logic [1:0] emb, input string tag);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        chk(16'(mode_a),   16'(ema), {tag, " mode_a"});
        chk(16'(mode_b),   16'(emb), {tag, " mode_b"});
        chk(16'(t_mode_a), 16'(ema), {tag, " top mode_a"});
        chk(16'(t_mode_b), 16'(emb), {tag, " top mode_b"});
    endtask

    // Read cycle with separate expectations for the two instances.
    task automatic rd2(input logic [7:0] a, input logic [1:0] es, input logic [15:0] ed,
                       input logic [1:0] ts, input logic [15:0] td, input string tag);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(16'(rd_valid),     16'd1,             {tag, " R12 rd_valid"});
        chk(16'(rd_src),       16'(es),           {tag, " src"});
        chk(rd_data,           ed,                {tag, " data"});
        chk(16'(rd_refused),   16'(es == SR),     {tag, " refused"});
        chk(16'(t_rd_src),     16'(ts),           {tag, " top src"});
        chk(t_rd_data,         td,                {tag, " top data"});
        chk(16'(t_rd_refused), 16'(ts == SR),     {tag, " top refused"});
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] es, input logic [15:0] ed,
                      input string tag);
        rd2(a, es, ed, es, ed, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(16'(mode_a), 16'(MA), "R11 reset mode_a");
        chk(16'(mode_b), 16'(MA), "R11 reset mode_b");
        chk(16'(rd_valid), 16'd0, "R11 reset rd_valid");
        rd(8'h05, SA, 16'hFFFF, "R11 erased word a");
        rd(8'hC3, SA, 16'hFFFF, "R11 erased word b");
    endtask

    task automatic t_cancel();
        wr(8'h20, 16'h0020, MA, MA, "R1 erase setup");
        wr(8'h20, 16'h0055, MA, MA, "R1 bad confirm");
        wr(8'h20, 16'h0070, MS, MA, "R1 read status");
        rd(8'h20, SS, 16'h0080, "R1 no op started");
        wr(8'h20, 16'h00FF, MA, MA, "R1 back to array");
    endtask

    task automatic t_prog_timing();
        wr(8'h90, 16'h0040, MA, MA, "R1 prog setup b");
        wr(8'h90, 16'h00AA, MA, MS, "R2 prog launch b");
        idle(PROG_CYC - 1);
        rd(8'h90, SS, 16'h0000, "R5 busy last cycle");
        rd(8'h90, SS, 16'h0080, "R5 ready after PROG_CYC");
        rd(8'h10, SA, 16'hFFFF, "R3 other bank array");
        wr(8'h80, 16'h00FF, MA, MA, "R5 leave status");
        rd(8'h90, SA, 16'h00AA, "R5 programmed word");
        wr(8'h90, 16'h0040, MA, MA, "R5 prog setup again");
        wr(8'h90, 16'h0F0F, MA, MS, "R5 prog AND");
        idle(PROG_CYC + 1);
        rd(8'h90, SS, 16'h0080, "R5 stays status");
        wr(8'h80, 16'h00FF, MA, MA, "R5 array b");
        rd(8'h90, SA, 16'h000A, "R5 AND result");
    endtask

    task automatic t_concurrent();
        wr(8'h05, 16'h0040, MA, MA, "R1 prog setup a");
        wr(8'h05, 16'h1234, MS, MA, "R2 prog launch a");
        rd(8'h85, SA, 16'hFFFF, "R3 read idle bank b");
        rd(8'h05, SS, 16'h0000, "R4 busy status a");
        wr(8'h00, 16'h00FF, MS, MA, "R6 array ignored");
        wr(8'h00, 16'h0090, MS, MA, "R6 id ignored");
        wr(8'h80, 16'h0040, MS, MA, "R6 second setup");
        wr(8'h90, 16'h0000, MS, MA, "R6 second start rejected");
        idle(PROG_CYC);
        wr(8'h00, 16'h00FF, MA, MA, "R5 array a");
        rd(8'h05, SA, 16'h1234, "R5 word a");
        rd(8'h90, SA, 16'h000A, "R6 word b untouched");
    endtask

    task automatic t_suspend();
        wr(8'h00, 16'h0020, MA, MA, "R1 erase setup a");
        wr(8'h03, 16'h00D0, MS, MA, "R2 erase launch a");
        idle(5);
        wr(8'h00, 16'h00B0, MS, MA, "R7 suspend");
        rd(8'h00, SS, 16'h00C0, "R7 ready+suspended");
        wr(8'h80, 16'h0020, MS, MA, "R7 erase b setup");
        wr(8'h80, 16'h00D0, MS, MA, "R7 erase b rejected");
        wr(8'h80, 16'h0040, MS, MA, "R7 prog b setup");
        wr(8'h88, 16'h1111, MS, MA, "R7 prog b rejected");
        wr(8'h10, 16'h0040, MS, MA, "R7 prog a setup");
        wr(8'h15, 16'h5555, MS, MA, "R7 prog in suspend");
        rd(8'h00, SS, 16'h0040, "R4 busy and suspended");
        idle(PROG_CYC);
        rd(8'h00, SS, 16'h00C0, "R7 prog done, still suspended");
        wr(8'h00, 16'h00FF, MA, MA, "R7 array during suspend");
        rd(8'h05, SA, 16'h1234, "R7 block not yet erased");
        rd(8'h15, SA, 16'h5555, "R7 program landed");
        rd(8'h88, SA, 16'hFFFF, "R7 bank b untouched");
        wr(8'h00, 16'h00D0, MS, MA, "R8 resume");
        rd(8'h00, SS, 16'h0000, "R8 running, not suspended");
        idle(ERASE_CYC);
        rd(8'h00, SS, 16'h0080, "R8 erase done");
        wr(8'h00, 16'h00FF, MA, MA, "R8 array a");
        rd(8'h05, SA, 16'hFFFF, "R8 block erased");
        rd(8'h15, SA, 16'h5555, "R8 other block kept");
    endtask

    task automatic t_ident();
        wr(8'h00, 16'h0090, MI, MA, "R9 id mode a");
        rd(8'h00, SI, IDW, "R9 id read idle");
        wr(8'h00, 16'h00FF, MA, MA, "R9 array a");
        wr(8'h81, 16'h0040, MA, MA, "R10 prog setup b");
        wr(8'h81, 16'h00F0, MA, MS, "R10 prog launch b");
        wr(8'h00, 16'h0090, MI, MS, "R10 id mode a");
        rd2(8'h00, SI, IDW, SR, 16'hFFFF, "R10 id while b busy");
        idle(PROG_CYC);
        wr(8'h80, 16'h00FF, MI, MA, "R10 array b");
        wr(8'h06, 16'h0040, MI, MA, "R10 prog setup a");
        wr(8'h06, 16'h0001, MS, MA, "R10 prog launch a");
        wr(8'h80, 16'h0090, MS, MI, "R10 id mode b");
        rd2(8'h80, SR, 16'hFFFF, SR, 16'hFFFF, "R10 id while a busy");
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_cancel();
        t_prog_timing();
        t_concurrent();
        t_suspend();
        t_ident();
        idle(2);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule